// File: doc/BRIEF.md
# Register snapshot capture controller

This block copies a bank of user flip-flops into a set of shadow cells so that their values can be read back later, and it can load the bank again from those cells. A capture can come from either of two paths. The first is a level on the user capture input, which is sampled on the user clock. The second is a capture opcode written through a small command port on a separate configuration clock. A restore opcode tells the register bank to reload itself from the shadow cells. Each shadow cell also serves as its register's init value. For that reason, a restore issued after a capture returns the captured values and not the parameterised init values.

The configuration domain holds a sequencer state machine with five states. `SQ_IDLE` accepts a command. `SQ_CAP_1` → `SQ_CAP_2` → `SQ_IDLE` drives the capture strobe for two configuration clocks. `SQ_RES_1` → `SQ_RES_2` → `SQ_IDLE` does the same for the restore strobe. Each strobe is brought into the user clock domain through a two-flop synchroniser followed by a rising-edge detector, so one command yields exactly one event.

The user domain holds a trigger state machine with two states. `TR_ARMED` moves to `TR_HELD` when the capture input is sampled high, and `TR_HELD` moves back to `TR_ARMED` when the input is sampled low. In one-shot mode, a capture fires only from `TR_ARMED`. The shadow vector can also be read as 32-bit words through a word address.

Top module: `snap_capture_ctrl`

## Requirements
- R1: While reset is low, `cap_active`, `restore_load`, `cap_err` and `cfg_cap_strobe` are 0. Before any capture, the shadow cells hold `INIT_VAL`. Asserting reset never changes the shadow cells.
- R2: With `one_shot` = 0, every rising `uclk` edge that samples `cap_req` high copies `live_in` into `shadow_out`, and `cap_active` is high for the cycle that follows.
- R3: With `one_shot` = 1, only the first rising edge that samples `cap_req` high performs a capture. No further capture happens until `cap_req` has been sampled low on an edge.
- R4: A command with `cmd_op` = 2'b01 (capture), accepted in `SQ_IDLE`, drives `cfg_cap_strobe` high for exactly two `cclk` cycles.
- R5: Each accepted capture command causes exactly one capture in the `uclk` domain, which copies `live_in` and pulses `cap_active` once.
- R6: A command with `cmd_op` = 2'b10 (restore) produces exactly one single-cycle `restore_load` pulse. During that pulse, `shadow_out` holds the most recently captured values, which the bank loads.
- R7: If a restore event and a capture land on the same `uclk` edge, the restore wins. The shadow cells are left unchanged, `cap_active` stays low, and `cap_err` pulses for one cycle alongside `restore_load`.
- R8: `rd_data` returns bits [32a+31:32a] of the shadow vector for word address a, with the bits above W read as zero. It returns zero for addresses at or beyond ceil(W/32).
- R9: Opcodes 2'b00 and 2'b11 are ignored. Any command that arrives while the sequencer is not in `SQ_IDLE` is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | User clock; trigger, shadow cells and flags |
| cclk | input | 1 | Configuration clock; command sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | User capture request, sampled on `uclk` |
| one_shot | input | 1 | 1 = capture only on the first edge of a request |
| cmd_valid | input | 1 | Command strobe, sampled on `cclk` |
| cmd_op | input | 2 | Opcode: 01 capture, 10 restore, others no-op |
| live_in | input | W | Live register bank values |
| shadow_out | output | W | Shadow cells; also the bank's restore/init value |
| restore_load | output | 1 | One-cycle pulse: bank loads `shadow_out` |
| rd_addr | input | AW | Readback word address |
| rd_data | output | 32 | Readback word |
| cap_active | output | 1 | One-cycle pulse after each performed capture |
| cap_err | output | 1 | One-cycle pulse when a capture is dropped for a restore |
| cfg_cap_strobe | output | 1 | Two-cycle capture strobe in the `cclk` domain |

## Verification
A user-path capture takes effect on the `uclk` edge that samples `cap_req`. The bench therefore drives on one falling edge and checks `shadow_out` and `cap_active` on the very next falling edge. The command path has a longer and variable latency. The strobe starts one `cclk` edge after acceptance, and the `uclk` event follows about three user edges after that. For these paths the bench counts strobe and pulse occurrences over a window of ten `cclk` cycles and compares the counts and the captured values once the window has closed. Readback is combinational, so it is checked one time step after `rd_addr` changes.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [1:0] {
        OP_NOP     = 2'b00,
        OP_CAPTURE = 2'b01,
        OP_RESTORE = 2'b10,
        OP_RSVD    = 2'b11
    } snap_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CAP_1,
        SQ_CAP_2,
        SQ_RES_1,
        SQ_RES_2
    } seq_state_e;

    typedef enum logic {
        TR_ARMED,
        TR_HELD
    } trig_state_e;
endpackage

// File: rtl/snap_cmd_seq.sv
module snap_cmd_seq
    import snap_pkg::*;
(
    input  logic       cclk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cap_strobe,
    output logic       res_strobe
);
    seq_state_e state_q, state_n;

    // state register
    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    if (snap_op_e'(cmd_op) == OP_CAPTURE)      state_n = SQ_CAP_1;
                    else if (snap_op_e'(cmd_op) == OP_RESTORE) state_n = SQ_RES_1;
                end
            end
            SQ_CAP_1: state_n = SQ_CAP_2;
            SQ_CAP_2: state_n = SQ_IDLE;
            SQ_RES_1: state_n = SQ_RES_2;
            SQ_RES_2: state_n = SQ_IDLE;
            default:  state_n = SQ_IDLE;
        endcase
    end

    // registered outputs, glitch-free for the crossing
    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            cap_strobe <= 1'b0;
            res_strobe <= 1'b0;
        end else begin
            cap_strobe <= (state_n == SQ_CAP_1) || (state_n == SQ_CAP_2);
            res_strobe <= (state_n == SQ_RES_1) || (state_n == SQ_RES_2);
        end
    end

    a_r4_strobe_holds: assert property (@(posedge cclk) disable iff (!rst_n)
        $rose(cap_strobe) |=> cap_strobe);
    a_r4_strobe_ends: assert property (@(posedge cclk) disable iff (!rst_n)
        (cap_strobe && $past(cap_strobe)) |=> !cap_strobe);
    a_r9_one_op_at_a_time: assert property (@(posedge cclk) disable iff (!rst_n)
        !(cap_strobe && res_strobe));
endmodule

// File: rtl/snap_pulse_sync.sv
module snap_pulse_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic evt
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= level_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign evt = s2_q & ~s3_q;

    a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/snap_trig.sv
module snap_trig
    import snap_pkg::*;
(
    input  logic uclk,
    input  logic rst_n,
    input  logic cap_req,
    input  logic one_shot,
    output logic fire
);
    trig_state_e state_q, state_n;

    always_ff @(posedge uclk or negedge rst_n) begin
        if (!rst_n) state_q <= TR_ARMED;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TR_ARMED: if (cap_req)  state_n = TR_HELD;
            TR_HELD:  if (!cap_req) state_n = TR_ARMED;
        endcase
    end

    // output process
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TR_ARMED: fire = cap_req;
            TR_HELD:  fire = cap_req && !one_shot;
        endcase
    end

    a_r3_single_shot: assert property (@(posedge uclk) disable iff (!rst_n)
        (one_shot && fire) |=> (!one_shot || !fire));
endmodule

// File: rtl/snap_capture_ctrl.sv
module snap_capture_ctrl #(
    parameter int             W        = 72,
    parameter int             AW       = 3,
    parameter logic [W-1:0]   INIT_VAL = '0
) (
    input  logic          uclk,
    input  logic          cclk,
    input  logic          rst_n,
    input  logic          cap_req,
    input  logic          one_shot,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [W-1:0]  live_in,
    output logic [W-1:0]  shadow_out,
    output logic          restore_load,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          cap_active,
    output logic          cap_err,
    output logic          cfg_cap_strobe
);
    localparam int NW    = (W + 31) / 32;
    localparam int NSLOT = 2 ** AW;

    logic cap_strb_c, res_strb_c;
    logic cmd_cap_evt, res_evt, user_fire, any_cap;

    snap_cmd_seq u_seq (
        .cclk      (cclk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cap_strobe(cap_strb_c),
        .res_strobe(res_strb_c)
    );

    snap_pulse_sync u_sync_cap (
        .clk     (uclk),
        .rst_n   (rst_n),
        .level_in(cap_strb_c),
        .evt     (cmd_cap_evt)
    );

    snap_pulse_sync u_sync_res (
        .clk     (uclk),
        .rst_n   (rst_n),
        .level_in(res_strb_c),
        .evt     (res_evt)
    );

    snap_trig u_trig (
        .uclk    (uclk),
        .rst_n   (rst_n),
        .cap_req (cap_req),
        .one_shot(one_shot),
        .fire    (user_fire)
    );

    assign any_cap        = user_fire | cmd_cap_evt;
    assign cfg_cap_strobe = cap_strb_c;

    // shadow cells: init value storage, deliberately outside reset
    logic [W-1:0] shadow_q = INIT_VAL;
    always_ff @(posedge uclk) begin
        if (any_cap && !res_evt) shadow_q <= live_in;
    end
    assign shadow_out = shadow_q;

    always_ff @(posedge uclk or negedge rst_n) begin
        if (!rst_n) begin
            cap_active   <= 1'b0;
            restore_load <= 1'b0;
            cap_err      <= 1'b0;
        end else begin
            cap_active   <= any_cap & ~res_evt;
            restore_load <= res_evt;
            cap_err      <= any_cap & res_evt;
        end
    end

    // readback word slots
    logic [NW*32-1:0] padded;
    always_comb begin
        padded        = '0;
        padded[W-1:0] = shadow_q;
    end

    logic [31:0] slot [NSLOT];
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g < NW) begin : g_word
            assign slot[g] = padded[g*32 +: 32];
        end else begin : g_zero
            assign slot[g] = '0;
        end
    end
    assign rd_data = slot[rd_addr];

    a_r2_copy_live: assert property (@(posedge uclk) disable iff (!rst_n)
        (any_cap && !res_evt) |=> (cap_active && shadow_q == $past(live_in)));
    a_r7_restore_wins: assert property (@(posedge uclk) disable iff (!rst_n)
        (res_evt && any_cap) |=> (cap_err && restore_load && !cap_active));
    a_r6_cells_hold_on_restore: assert property (@(posedge uclk) disable iff (!rst_n)
        res_evt |=> $stable(shadow_q));
endmodule

// File: tb/sim_snap_capture_ctrl.sv
module sim_snap_capture_ctrl;
    localparam int W  = 72;
    localparam int AW = 3;
    localparam logic [W-1:0] INIT = 72'h5A_0123_4567_89AB_CDEF;

    logic uclk = 1'b0, cclk = 1'b0, rst_n = 1'b0;
    logic cap_req = 1'b0, one_shot = 1'b0, cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [W-1:0] live_in = '0;
    logic [W-1:0] shadow_out;
    logic restore_load, cap_active, cap_err, cfg_cap_strobe;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;

    always #10 uclk = ~uclk;   // 50 MHz
    always #30 cclk = ~cclk;

    snap_capture_ctrl #(.W(W), .AW(AW), .INIT_VAL(INIT)) u0 (
        .uclk(uclk), .cclk(cclk), .rst_n(rst_n), .cap_req(cap_req),
        .one_shot(one_shot), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .live_in(live_in), .shadow_out(shadow_out), .restore_load(restore_load),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_active(cap_active),
        .cap_err(cap_err), .cfg_cap_strobe(cfg_cap_strobe)
    );

    int checks = 0, fails = 0;
    int cap_cnt = 0, res_cnt = 0, err_cnt = 0, strb_cnt = 0, conf_seen = 0;
    bit conf_en = 1'b0, done = 1'b0;
    logic [W-1:0] res_val = '0, prev_sh = '0;

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int i);
        pat = {8'(i * 13 + 7), 32'(i) * 32'h9E3779B1, 32'hDEAD0000 ^ 32'(i)};
    endfunction

    task automatic clear_counts();
        @(posedge uclk); #1;
        cap_cnt = 0; res_cnt = 0; err_cnt = 0; strb_cnt = 0; conf_seen = 0;
    endtask

    task automatic send_cmd(input logic [1:0] op);
        @(negedge cclk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge cclk); cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    always @(negedge uclk) begin
        if (rst_n) begin
            if (cap_active)   cap_cnt++;
            if (cap_err)      err_cnt++;
            if (restore_load) begin
                res_cnt++;
                res_val = shadow_out;
                if (conf_en) begin
                    conf_seen++;
                    chk(cap_err && !cap_active, "R7 flags", {94'b0, cap_err, cap_active}, 96'h2);
                    chk(shadow_out == prev_sh, "R7 cells kept", 96'(shadow_out), 96'(prev_sh));
                end
            end
        end
        prev_sh = shadow_out;
    end

    always @(negedge cclk) if (rst_n && cfg_cap_strobe) strb_cnt++;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [95:0] padx;
        // R1 reset state
        #95;
        chk(shadow_out == INIT, "R1 init", 96'(shadow_out), 96'(INIT));
        chk(!cap_active && !restore_load && !cap_err && !cfg_cap_strobe, "R1 flags",
            {92'b0, cap_active, restore_load, cap_err, cfg_cap_strobe}, 96'h0);
        #10 rst_n = 1'b1;

        // R2 level-mode sweep
        for (int i = 0; i < 24; i++) begin
            @(negedge uclk); live_in = pat(i); cap_req = 1'b1;
            @(negedge uclk);
            chk(shadow_out == pat(i) && cap_active, "R2 level capture",
                {23'b0, cap_active, shadow_out}, {24'h1, pat(i)});
            cap_req = 1'b0;
        end
        @(negedge uclk);
        chk(!cap_active, "R2 no capture when low", 96'(cap_active), 96'h0);

        // R8 readback sweep over every address
        padx = {24'b0, pat(23)};
        for (int a = 0; a < 8; a++) begin
            rd_addr = AW'(a); #1;
            chk(rd_data == ((a < 3) ? padx[a*32 +: 32] : 32'h0), "R8 readback",
                96'(rd_data), 96'((a < 3) ? padx[a*32 +: 32] : 32'h0));
        end

        // R3 one-shot
        @(negedge uclk); one_shot = 1'b1; cap_req = 1'b1; live_in = pat(50);
        @(negedge uclk);
        chk(cap_active && shadow_out == pat(50), "R3 first edge",
            {23'b0, cap_active, shadow_out}, {24'h1, pat(50)});
        for (int k = 0; k < 3; k++) begin
            live_in = pat(51 + k);
            @(negedge uclk);
            chk(!cap_active && shadow_out == pat(50), "R3 held edge",
                {23'b0, cap_active, shadow_out}, {24'h0, pat(50)});
        end
        cap_req = 1'b0;
        @(negedge uclk);
        chk(!cap_active, "R3 release", 96'(cap_active), 96'h0);
        cap_req = 1'b1; live_in = pat(60);
        @(negedge uclk);
        chk(cap_active && shadow_out == pat(60), "R3 re-armed",
            {23'b0, cap_active, shadow_out}, {24'h1, pat(60)});
        cap_req = 1'b0; one_shot = 1'b0;

        // R4 / R5 command capture, with a restore sent while busy (R9)
        clear_counts();
        @(negedge uclk); live_in = pat(70);
        @(negedge cclk); cmd_valid = 1'b1; cmd_op = 2'b01;
        @(negedge cclk); cmd_op = 2'b10;
        @(negedge cclk); cmd_valid = 1'b0; cmd_op = 2'b00;
        repeat (10) @(negedge cclk);
        chk(strb_cnt == 2, "R4 strobe length", 96'(strb_cnt), 96'd2);
        chk(cap_cnt == 1, "R5 single capture", 96'(cap_cnt), 96'd1);
        chk(shadow_out == pat(70), "R5 captured value", 96'(shadow_out), 96'(pat(70)));
        chk(res_cnt == 0, "R9 busy command ignored", 96'(res_cnt), 96'd0);

        // R6 restore returns captured values, not INIT
        clear_counts();
        @(negedge uclk); live_in = pat(80);
        send_cmd(2'b10);
        repeat (10) @(negedge cclk);
        chk(res_cnt == 1, "R6 one restore pulse", 96'(res_cnt), 96'd1);
        chk(res_val == pat(70), "R6 restore value", 96'(res_val), 96'(pat(70)));
        chk(cap_cnt == 0 && strb_cnt == 0, "R6 no capture", 96'(cap_cnt + strb_cnt), 96'd0);

        // R9 no-op opcodes
        clear_counts();
        send_cmd(2'b00);
        send_cmd(2'b11);
        repeat (10) @(negedge cclk);
        chk(strb_cnt == 0 && cap_cnt == 0 && res_cnt == 0, "R9 no-op opcodes",
            96'(strb_cnt + cap_cnt + res_cnt), 96'd0);
        chk(shadow_out == pat(70), "R9 cells unchanged", 96'(shadow_out), 96'(pat(70)));

        // R7 restore collides with level capture
        clear_counts();
        conf_en = 1'b1;
        fork
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge uclk); live_in = pat(100 + k); cap_req = 1'b1;
                end
                @(negedge uclk); cap_req = 1'b0;
            end
            begin
                repeat (3) @(negedge cclk);
                cmd_valid = 1'b1; cmd_op = 2'b10;
                @(negedge cclk); cmd_valid = 1'b0; cmd_op = 2'b00;
            end
        join
        repeat (4) @(negedge uclk);
        conf_en = 1'b0;
        chk(conf_seen == 1 && err_cnt == 1, "R7 one dropped capture",
            96'(err_cnt), 96'd1);
        chk(cap_cnt == 39, "R7 remaining captures", 96'(cap_cnt), 96'd39);

        // R1 reset leaves the shadow cells alone
        @(negedge uclk); #3 rst_n = 1'b0;
        #4;
        chk(shadow_out == pat(139), "R1 cells kept in reset", 96'(shadow_out), 96'(pat(139)));
        chk(!cap_active && !restore_load && !cap_err, "R1 flags in reset",
            {93'b0, cap_active, restore_load, cap_err}, 96'h0);
        repeat (3) @(negedge uclk);
        #3 rst_n = 1'b1;
        @(negedge uclk);
        chk(shadow_out == pat(139), "R1 cells kept after reset", 96'(shadow_out), 96'(pat(139)));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule